// File: doc/BRIEF.md
# Synchronous Burst SRAM Datapath

This block is a clocked single-port word memory with a 32-bit data bus split into four byte lanes. A burst sequencer upstream supplies one word address per clock. On each rising edge the block samples three chip enables, the write controls, the address and the write data, and turns them into one command: deselect, read or write. A write updates either the chosen byte lanes or all four lanes.

The read path can be switched at run time between two modes. In flow-through mode the word read at an edge appears right after that edge. In pipelined mode it passes through one more output register and appears one edge later. Back-to-back reads deliver one word per clock in both modes.

The output drivers are modelled as a single valid flag. Outputs switch off on a deselect two edges after the deselect is sampled, so the last word stays on the bus for one full extra cycle. The output enable and the sleep input act on the flag without waiting for a clock. Sleep also blocks every access while the memory keeps its contents.

Top module: `sbs_sram`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears its state. After reset, `rvalid` is 0 and `rdata` is 0.
- R2: A cycle is selected only when `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0 and `sleep`=0. Any other combination is a deselect: it neither writes nor reads.
- R3: A selected cycle with `wr_byte_n`=0 and `wr_all_n`=1 writes byte lane k (bits 8k+7..8k of `wdata`) exactly when `lane_n[k]`=0. All other lanes of that word keep their previous value.
- R4: A selected cycle with `wr_all_n`=0 writes all four lanes, whatever the values of `wr_byte_n` and `lane_n`.
- R5: A selected cycle that is not a write is a read. This includes `wr_byte_n`=0 with `lane_n`=4'b1111.
- R6: With `pipe_mode`=0 (flow-through), a read sampled at edge k puts the word on `rdata` and raises `rvalid` (when `oe_n`=0) right after edge k. Consecutive reads deliver one word per clock.
- R7: With `pipe_mode`=1 (pipelined), a read sampled at edge k puts the word on `rdata` and raises `rvalid` after edge k+1. Consecutive reads deliver one word per clock.
- R8: When a deselect sampled at edge j follows a read, `rvalid` stays high with the last read word held on `rdata` until edge j+1, and goes low after edge j+1. This holds in both modes.
- R9: A selected write turns `rvalid` off with the same latency a read would turn it on: after its own edge in flow-through mode, and one edge later in pipelined mode.
- R10: `rvalid` is low whenever `oe_n`=1 and follows `oe_n` without waiting for a clock edge.
- R11: While `sleep`=1, `rvalid` is forced low at once and writes are ignored. Memory contents are kept across sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | 0 = flow-through reads, 1 = pipelined reads |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address from the burst sequencer |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request, active high |
| rdata | output | LANES*LANE_W | Read data |
| rvalid | output | 1 | Output drivers on |

## Verification
The hardest case to reach is the one-cycle hold of the dual-cycle deselect. It only shows up in the cycle right after a read is followed by a deselect, and it has to be told apart from the immediate turn-off that a write causes at the same point. The stimulus walks read, read, deselect, deselect in both modes and samples `rvalid` and `rdata` after each edge. It then places a write directly after a read, so the turn-off a write causes and the turn-off a deselect causes land one cycle apart and can be compared.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             sleep,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_n,
  output cmd_e             cmd,
  output logic [LANES-1:0] lane_we
);
  logic selected;
  logic byte_req;

  always_comb begin
    selected = !sel_a_n && sel_b && !sel_c_n && !sleep;
    byte_req = !wr_byte_n && (lane_n != {LANES{1'b1}});
    cmd      = CMD_DESEL;
    lane_we  = '0;
    if (selected) begin
      if (!wr_all_n) begin
        cmd     = CMD_WRITE;
        lane_we = {LANES{1'b1}};
      end else if (byte_req) begin
        cmd     = CMD_WRITE;
        lane_we = ~lane_n;
      end else begin
        cmd = CMD_READ;
      end
    end
  end
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= mem[addr];
  end
endmodule

// File: rtl/sbs_out_ctrl.sv
module sbs_out_ctrl
  import sbs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  cmd_e              cmd,
  input  logic [DATA_W-1:0] ram_q,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              s1_rd, s2_rd, s1_ds;
  logic [DATA_W-1:0] out_q;
  logic              drv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rd <= 1'b0;
      s2_rd <= 1'b0;
      s1_ds <= 1'b0;
      out_q <= '0;
    end else begin
      s1_rd <= (cmd == CMD_READ);
      s1_ds <= (cmd == CMD_DESEL);
      s2_rd <= s1_rd;
      if (s1_rd) out_q <= ram_q;
    end
  end

  always_comb begin
    if (pipe_mode) drv = s2_rd;
    else           drv = s1_rd || (s2_rd && s1_ds);
    rdata  = pipe_mode ? out_q : ram_q;
    rvalid = drv && !oe_n && !sleep;
  end

  // R6
  ft_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && cmd == CMD_READ) |=> (drv || pipe_mode));

  // R8
  dcd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && cmd == CMD_DESEL && s1_rd) |=> (drv || pipe_mode));

  // R9
  ft_wr_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && cmd == CMD_WRITE) |=> (!drv || pipe_mode));

  // R7
  pipe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && cmd != CMD_READ) |-> ##2 (!drv || !pipe_mode));
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pipe_mode,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  cmd_e              cmd;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] ram_q;

  sbs_cmd_decode #(.LANES(LANES)) u_dec (
    .sel_a_n  (sel_a_n),
    .sel_b    (sel_b),
    .sel_c_n  (sel_c_n),
    .sleep    (sleep),
    .wr_all_n (wr_all_n),
    .wr_byte_n(wr_byte_n),
    .lane_n   (lane_n),
    .cmd      (cmd),
    .lane_we  (lane_we)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbs_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk (clk),
      .rst (rst),
      .we  (lane_we[g]),
      .re  (cmd == CMD_READ),
      .addr(addr),
      .wd  (wdata[g*LANE_W +: LANE_W]),
      .rq  (ram_q[g*LANE_W +: LANE_W])
    );
  end

  sbs_out_ctrl #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .pipe_mode(pipe_mode),
    .cmd      (cmd),
    .ram_q    (ram_q),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .rdata    (rdata),
    .rvalid   (rvalid)
  );

  // R11
  sleep_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (lane_we == '0));

  // R4
  all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_all_n && cmd == CMD_WRITE) |-> (&lane_we));

  // R2
  desel_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_a_n || !sel_b || sel_c_n) |-> (lane_we == '0 && cmd != CMD_READ));
endmodule

// File: tb/sbs_sram_bench.sv
module sbs_sram_bench;
  localparam int PERIOD = 10;
  localparam int VW = 83;

  logic        clk = 1'b0;
  logic        rst, pipe_mode, sel_a_n, sel_b, sel_c_n;
  logic [7:0]  addr;
  logic        wr_all_n, wr_byte_n;
  logic [3:0]  lane_n;
  logic [31:0] wdata;
  logic        oe_n, sleep;
  logic [31:0] rdata;
  logic        rvalid;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  sbs_sram u_sbs_sram (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .addr(addr), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_n(lane_n), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct packed {
    logic        a_n, b, c_n, wa_n, wb_n;
    logic [3:0]  ln;
    logic [7:0]  ad;
    logic [31:0] wd;
    logic        ev, chk;
    logic [31:0] ed;
  } vec_t;

  // flow-through mode; expectations sampled after the edge that takes the row
  localparam logic [VW-1:0] VEC [13] = '{
    {5'b01001, 4'hF, 8'h01, 32'h11223344, 2'b00, 32'h0},        // R4 write all
    {5'b01001, 4'hF, 8'h02, 32'hA5A5A5A5, 2'b00, 32'h0},        // R4
    {5'b01010, 4'b1010, 8'h01, 32'hFFEEDDCC, 2'b00, 32'h0},     // R3 lanes 0,2
    {5'b01011, 4'hF, 8'h01, 32'h0, 2'b11, 32'h11EE33CC},        // R3 R6 read
    {5'b01011, 4'hF, 8'h02, 32'h0, 2'b11, 32'hA5A5A5A5},        // R6 next beat
    {5'b01010, 4'hF, 8'h01, 32'h0, 2'b11, 32'h11EE33CC},        // R5 no lanes
    {5'b01000, 4'b0111, 8'h02, 32'h01020304, 2'b00, 32'h0},     // R4 overrides
    {5'b01011, 4'hF, 8'h02, 32'h0, 2'b11, 32'h01020304},        // R4 read back
    {5'b00011, 4'hF, 8'h01, 32'h0, 2'b11, 32'h01020304},        // R8 hold
    {5'b00011, 4'hF, 8'h01, 32'h0, 2'b01, 32'h01020304},        // R8 off
    {5'b11011, 4'hF, 8'h02, 32'h0, 2'b00, 32'h0},               // R2 sel_a_n
    {5'b01101, 4'hF, 8'h02, 32'hFFFFFFFF, 2'b00, 32'h0},        // R2 sel_c_n
    {5'b01011, 4'hF, 8'h02, 32'h0, 2'b11, 32'h01020304}         // R2 unchanged
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic drive(input logic a_n, input logic b, input logic c_n,
                       input logic wa, input logic wb, input logic [3:0] ln,
                       input logic [7:0] ad, input logic [31:0] wd);
    sel_a_n = a_n; sel_b = b; sel_c_n = c_n;
    wr_all_n = wa; wr_byte_n = wb; lane_n = ln; addr = ad; wdata = wd;
  endtask

  task automatic rd(input logic [7:0] ad);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, ad, 32'h0);
  endtask

  task automatic wr(input logic [7:0] ad, input logic [31:0] wd);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, ad, wd);
  endtask

  task automatic desel();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'hF, 8'h0, 32'h0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst = 1'b1; pipe_mode = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    desel();
    step(); step();
    rst = 1'b0;
    check("R1 rvalid", {31'b0, rvalid}, 32'h0);
    check("R1 rdata", rdata, 32'h0);

    for (int i = 0; i < 13; i++) begin
      vec_t v;
      v = VEC[i];
      drive(v.a_n, v.b, v.c_n, v.wa_n, v.wb_n, v.ln, v.ad, v.wd);
      step();
      check($sformatf("R2-table row %0d rvalid", i), {31'b0, rvalid}, {31'b0, v.ev});
      if (v.chk) check($sformatf("R6 table row %0d rdata", i), rdata, v.ed);
    end

    // R9 flow-through: write right after a read turns off at once
    wr(8'h03, 32'h0BADF00D);
    step();
    check("R9 flow write off", {31'b0, rvalid}, 32'h0);

    // R10 output enable acts without a clock
    rd(8'h03);
    step();
    check("R10 on", {31'b0, rvalid}, 32'h1);
    check("R10 data", rdata, 32'h0BADF00D);
    oe_n = 1'b1; #1;
    check("R10 oe_n high", {31'b0, rvalid}, 32'h0);
    oe_n = 1'b0; #1;
    check("R10 oe_n low", {31'b0, rvalid}, 32'h1);

    // R11 sleep
    sleep = 1'b1; #1;
    check("R11 immediate off", {31'b0, rvalid}, 32'h0);
    wr(8'h01, 32'hDEADBEEF);
    step();
    check("R11 off in sleep", {31'b0, rvalid}, 32'h0);
    sleep = 1'b0;
    rd(8'h01);
    step();
    check("R11 valid after wake", {31'b0, rvalid}, 32'h1);
    check("R11 contents kept", rdata, 32'h11EE33CC);

    // switch to pipelined while idle
    desel(); step(); step();
    pipe_mode = 1'b1;
    rd(8'h01); step();
    check("R7 not yet", {31'b0, rvalid}, 32'h0);
    rd(8'h02); step();
    check("R7 first word valid", {31'b0, rvalid}, 32'h1);
    check("R7 first word", rdata, 32'h11EE33CC);
    desel(); step();
    check("R8 pipe hold valid", {31'b0, rvalid}, 32'h1);
    check("R8 pipe hold data", rdata, 32'h01020304);
    desel(); step();
    check("R8 pipe off", {31'b0, rvalid}, 32'h0);

    // R9 pipelined write turns off one edge later
    rd(8'h01); step();
    wr(8'h04, 32'h12345678); step();
    check("R9 pipe read still on", {31'b0, rvalid}, 32'h1);
    desel(); step();
    check("R9 pipe write off", {31'b0, rvalid}, 32'h0);
    rd(8'h04); step();
    desel(); step();
    check("R7 pipe written word valid", {31'b0, rvalid}, 32'h1);
    check("R7 pipe written word", rdata, 32'h12345678);

    report();
    $finish;
  end
endmodule